// File: doc/BRIEF.md
# Dual-Mode Quotient Rounding Unit

This block rounds the raw quotient word of a floating-point divider to nearest. The word holds either one double-precision quotient across all 64 bits or two single-precision quotients, one in each 32-bit half. A mode input picks between the two. The block returns the rounded word, a per-lane overflow flag that also asks the exponent logic for a +1, and a renormalized word in which each overflowing lane is shifted right by one.

Each lane has its own round-up decision. The top bit of the lane picks the mantissa window. From that window the decision takes the kept LSB, the two bits just below it (guard and round) and the OR of everything lower (sticky). A single adder path then applies the round-up. It is split into two 32-bit incrementers. In double mode they are chained by carry. In dual mode they are kept apart.

The rounding logic itself is purely combinational. A parameter adds one output register stage, and that stage is present by default.

Top module: `dual_round_unit`

## Requirements
- R1: With dp_mode=1, the mantissa is quo_in[63:11] when quo_in[63]=1 and quo_in[62:10] when quo_in[63]=0. In rnd_word, every bit below the kept LSB is zero.
- R2: With dp_mode=0, each 32-bit half is rounded on its own. Within a half, the mantissa is bits [31:8] when bit 31 of that half is 1, and bits [30:7] when bit 31 is 0. Every bit below the kept LSB of a half is zero in rnd_word.
- R3: A lane rounds up, by adding one at its kept LSB, when the guard bit is 1 and either the round bit or the sticky bit is 1.
- R4: When guard=1, round=0 and sticky=0 (a tie), the lane rounds up only if its kept LSB is 1.
- R5: When the guard bit is 0, the lane is truncated.
- R6: In double mode, a carry out of bit 31 propagates into bit 32.
- R7: In dual mode, a carry out of the low half does not change the high half.
- R8: lane_ovf[1] flags a carry out of bit 63, which is the double lane or the high single lane. lane_ovf[0] flags a carry out of bit 31 in dual mode only and is 0 in double mode. A set flag is the lane's exponent increment request.
- R9: In norm_word, an overflowing lane reads as its top bit 1 with all other bits 0. A lane that does not overflow equals rnd_word.
- R10: With the output stage present, the outputs show the result for the inputs one clock edge later. All outputs are 0 while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| dp_mode | input | 1 | 1 = one double lane, 0 = two single lanes |
| quo_in | input | 64 | Unrounded quotient word |
| rnd_word | output | 64 | Rounded word, carries out of lanes dropped |
| norm_word | output | 64 | Rounded word after 1-bit renormalization of overflowing lanes |
| lane_ovf | output | 2 | Per-lane overflow and exponent increment request |

## Verification
The bench targets the carry across bit 32. A design that isolates the halves in double mode would return 0x8000_0000_0000_0000 instead of 0x8000_0001_0000_0000, and one that chains them in dual mode would disturb the high lane when the low lane is all ones. Ties with both LSB values are driven: a design that always rounds ties up or always truncates them gets one of the pair wrong. The bench also covers an all-ones lane, where a missing overflow flag or renormalization shows up as a zero mantissa. It covers a lane whose top bit is clear: a window picked off the wrong top bit moves the rounding point by one place and shifts the result.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    typedef struct packed {
        logic lsb;
        logic guard;
        logic rbit;
        logic sticky;
    } rnd_bits_t;

    // nearest, ties to even
    function automatic logic round_up(input rnd_bits_t b);
        return b.guard & (b.rbit | b.sticky | b.lsb);
    endfunction

endpackage

// File: rtl/rnd_lane_decide.sv
module rnd_lane_decide
    import rnd_pkg::*;
#(
    parameter int LW = 32,
    parameter int MW = 24
) (
    input  logic [LW-1:0] lane_in,
    output logic [LW-1:0] lane_trunc,
    output logic [LW-1:0] lane_ulp
);
    localparam int POS_TOP = LW - MW;
    localparam int POS_LOW = LW - MW - 1;

    rnd_bits_t bits;
    logic      up;
    int        p;

    always_comb begin
        p = lane_in[LW-1] ? POS_TOP : POS_LOW;
        bits = '0;
        lane_trunc = '0;
        for (int i = 0; i < LW; i++) begin
            if (i == p)     bits.lsb   = lane_in[i];
            if (i == p - 1) bits.guard = lane_in[i];
            if (i == p - 2) bits.rbit  = lane_in[i];
            if (i <  p - 2) bits.sticky = bits.sticky | lane_in[i];
            if (i >= p)     lane_trunc[i] = lane_in[i];
        end
        up = round_up(bits);
        lane_ulp = '0;
        for (int i = 0; i < LW; i++) begin
            if (i == p) lane_ulp[i] = up;
        end
    end

endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
    parameter int W = 32
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] addend,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, base} + {1'b0, addend} + {{W{1'b0}}, cin};
        sum  = full[W-1:0];
        cout = full[W];
    end

endmodule

// File: rtl/dual_round_unit.sv
module dual_round_unit #(
    parameter int LANE_W  = 32,
    parameter int DP_MANT = 53,
    parameter int SP_MANT = 24,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dp_mode,
    input  logic [2*LANE_W-1:0]   quo_in,
    output logic [2*LANE_W-1:0]   rnd_word,
    output logic [2*LANE_W-1:0]   norm_word,
    output logic [1:0]            lane_ovf
);
    localparam int WORD_W = 2 * LANE_W;
    localparam int DP_LO  = WORD_W - DP_MANT - 1;
    localparam int SP_LO  = LANE_W - SP_MANT - 1;

    logic [WORD_W-1:0] dp_trunc, dp_ulp;
    logic [LANE_W-1:0] lo_trunc, lo_ulp, hi_trunc, hi_ulp;
    logic [WORD_W-1:0] base_w;
    logic [LANE_W-1:0] add_lo, add_hi, sum_lo, sum_hi;
    logic              c_lo, c_hi, cin_hi;
    logic [WORD_W-1:0] rnd_c, norm_c;
    logic [1:0]        ovf_c;

    rnd_lane_decide #(.LW(WORD_W), .MW(DP_MANT)) u_dp_dec (
        .lane_in(quo_in), .lane_trunc(dp_trunc), .lane_ulp(dp_ulp));

    rnd_lane_decide #(.LW(LANE_W), .MW(SP_MANT)) u_lo_dec (
        .lane_in(quo_in[LANE_W-1:0]), .lane_trunc(lo_trunc), .lane_ulp(lo_ulp));

    rnd_lane_decide #(.LW(LANE_W), .MW(SP_MANT)) u_hi_dec (
        .lane_in(quo_in[WORD_W-1:LANE_W]), .lane_trunc(hi_trunc), .lane_ulp(hi_ulp));

    always_comb begin
        base_w = dp_mode ? dp_trunc : {hi_trunc, lo_trunc};
        add_lo = dp_mode ? dp_ulp[LANE_W-1:0] : lo_ulp;
        add_hi = dp_mode ? dp_ulp[WORD_W-1:LANE_W] : hi_ulp;
        cin_hi = dp_mode & c_lo;
    end

    rnd_incr #(.W(LANE_W)) u_inc_lo (
        .base(base_w[LANE_W-1:0]), .addend(add_lo), .cin(1'b0),
        .sum(sum_lo), .cout(c_lo));

    rnd_incr #(.W(LANE_W)) u_inc_hi (
        .base(base_w[WORD_W-1:LANE_W]), .addend(add_hi), .cin(cin_hi),
        .sum(sum_hi), .cout(c_hi));

    always_comb begin
        rnd_c  = {sum_hi, sum_lo};
        ovf_c  = {c_hi, ~dp_mode & c_lo};
        norm_c = rnd_c;
        if (dp_mode) begin
            if (c_hi) norm_c = {1'b1, rnd_c[WORD_W-1:1]};
        end else begin
            if (c_lo) norm_c[LANE_W-1:0]      = {1'b1, sum_lo[LANE_W-1:1]};
            if (c_hi) norm_c[WORD_W-1:LANE_W] = {1'b1, sum_hi[LANE_W-1:1]};
        end
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rnd_word  <= '0;
                    norm_word <= '0;
                    lane_ovf  <= '0;
                end else begin
                    rnd_word  <= rnd_c;
                    norm_word <= norm_c;
                    lane_ovf  <= ovf_c;
                end
            end
        end else begin : g_comb
            always_comb begin
                rnd_word  = rnd_c;
                norm_word = norm_c;
                lane_ovf  = ovf_c;
            end
        end
    endgenerate

    // R8
    dp_low_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_mode |-> !ovf_c[0]);

    // R9
    hi_norm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_c[1] |-> (norm_c[WORD_W-1] && norm_c[WORD_W-2:LANE_W] == '0));

    // R9
    lo_norm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_c[0] |-> (norm_c[LANE_W-1] && norm_c[LANE_W-2:0] == '0));

    // R1
    dp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_mode |-> rnd_c[DP_LO-1:0] == '0);

    // R2
    sp_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dp_mode |-> (rnd_c[SP_LO-1:0] == '0 && rnd_c[LANE_W+SP_LO-1:LANE_W] == '0));

endmodule

// File: tb/test_dual_round_unit.sv
`timescale 1ns/1ps
module test_dual_round_unit;

    typedef struct {
        logic [63:0] rnd;
        logic [63:0] norm;
        logic [1:0]  ovf;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dp_mode = 1'b0;
    logic [63:0] quo_in = '0;
    logic [63:0] rnd_word, norm_word;
    logic [1:0]  lane_ovf;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];
    exp_t last_exp;

    always #2.5 clk = ~clk;

    dual_round_unit i_dual_round_unit (
        .clk(clk), .rst_n(rst_n), .dp_mode(dp_mode), .quo_in(quo_in),
        .rnd_word(rnd_word), .norm_word(norm_word), .lane_ovf(lane_ovf));

    task automatic check64(input string tag, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic void lane_model(input logic [63:0] x, input int lw, input int mw,
                                       output logic [63:0] r, output logic ovf);
        int pos;
        logic [64:0] m;
        logic g, rb, s, l;
        logic [63:0] lmask;
        lmask = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
        pos = x[lw-1] ? (lw - mw) : (lw - mw - 1);
        m = 65'(x >> pos);
        m = m & ((65'd1 << (lw - pos)) - 65'd1);
        l = x[pos];
        g = x[pos-1];
        rb = x[pos-2];
        s = (x & ((64'd1 << (pos - 2)) - 64'd1)) != 64'd0;
        if (g && (rb || s || l)) m = m + 65'd1;
        ovf = m[lw-pos];
        r = 64'(m << pos) & lmask;
    endfunction

    function automatic exp_t model(input logic dp, input logic [63:0] q, input string tag);
        exp_t e;
        logic [63:0] r0, r1;
        logic o0, o1;
        e.tag = tag;
        if (dp) begin
            lane_model(q, 64, 53, r1, o1);
            e.rnd = r1;
            e.ovf = {o1, 1'b0};
            e.norm = o1 ? 64'h8000_0000_0000_0000 : r1;
        end else begin
            lane_model({32'h0, q[31:0]}, 32, 24, r0, o0);
            lane_model({32'h0, q[63:32]}, 32, 24, r1, o1);
            e.rnd = {r1[31:0], r0[31:0]};
            e.ovf = {o1, o0};
            e.norm = {o1 ? 32'h8000_0000 : r1[31:0], o0 ? 32'h8000_0000 : r0[31:0]};
        end
        return e;
    endfunction

    task automatic drive(input logic dp, input logic [63:0] q, input string tag);
        exp_t e;
        @(negedge clk);
        dp_mode = dp;
        quo_in = q;
        e = model(dp, q, tag);
        exp_q.push_back(e);
        #1;
        // R10: output must not move before the next edge
        check64("R10", "hold before edge", rnd_word, last_exp.rnd);
        last_exp = e;
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check64(e.tag, "rnd_word", rnd_word, e.rnd);
                check64(e.tag, "norm_word", norm_word, e.norm);
                check64(e.tag, "lane_ovf", {62'd0, lane_ovf}, {62'd0, e.ovf});
            end
        end
    end

    initial begin : watchdog
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [63:0] lfsr;
        dp_mode = 1'b1;
        quo_in = '1;
        repeat (3) @(negedge clk);
        // R10 reset clears outputs
        check64("R10", "reset rnd_word", rnd_word, 64'h0);
        check64("R10", "reset norm_word", norm_word, 64'h0);
        check64("R10", "reset lane_ovf", {62'd0, lane_ovf}, 64'h0);
        last_exp.rnd = '0;
        rst_n = 1'b1;

        drive(1'b1, 64'h8000_0000_0000_0600, "R1");
        drive(1'b1, 64'h4000_0000_0000_0300, "R1");
        drive(1'b1, 64'h8000_0000_0000_0401, "R3");
        drive(1'b1, 64'h8000_0000_0000_0400, "R4");
        drive(1'b1, 64'h8000_0000_0000_0C00, "R4");
        drive(1'b1, 64'h8000_0000_0000_03FF, "R5");
        drive(1'b1, 64'h8000_0000_FFFF_FC00, "R6");
        drive(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        drive(1'b0, 64'h8000_00C0_4000_0060, "R2");
        drive(1'b0, 64'h7FFF_FFFF_0000_0000, "R2");
        drive(1'b0, 64'h8000_0000_FFFF_FFFF, "R7");
        drive(1'b0, 64'hFFFF_FFFF_8000_0000, "R8");
        drive(1'b0, 64'h8000_0080_8000_0180, "R4");
        drive(1'b0, 64'h8000_003F_8000_0040, "R5");
        drive(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R9");
        drive(1'b1, 64'h8000_0000_0000_0000, "R9");

        lfsr = 64'hACE1_2468_1357_BDF0;
        for (int k = 0; k < 24; k++) begin
            lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
            drive(lfsr[5], lfsr, "R3");
        end

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule